// File: doc/BRIEF.md
# Repeater Port Event Interrupt Register Bank

This block collects per-port event pulses from an 8-port repeater manager and turns them into sticky status bits. It also produces one interrupt line for the host CPU. Port events come in six kinds, arranged in three pairs: link change with partition change, rate mismatch with jabber, and isolation with source-address change. Each pair shares one 16-bit status register. The first event of the pair sits in the low byte and the second in the high byte, with bit *n* of each byte standing for port *n*. Every status register has a mask register beside it, where a 1 blocks that bit from the interrupt. Two packet events get their own small status register: frame sent and management frame received. A control register holds the masks for those two events and a self-clearing soft-reset bit.

Reading a status register returns its contents and clears it in the same cycle. An event that lands in the same cycle as the clearing read is kept. Writing 1 to the soft-reset bit starts a two-state sequencer. The sequencer moves from `SR_IDLE` to `SR_FIRE` when it sees that write, holds the management reset output high for one cycle, and always goes back to `SR_IDLE` on the next edge. That return clears every status and mask bit in the bank.

Top module: `irq_bank`

## Requirements
- R1: Register select codes: 0 = link(low)/partition(high) status, 1 = its mask, 2 = rate-mismatch(low)/jabber(high) status, 3 = its mask, 4 = isolation(low)/source-address-change(high) status, 5 = its mask, 6 = packet status, 7 = packet control. `rd_data` always shows the selected register, and bit *n* of each byte is port *n*.
- R2: An event pulse sets its status bit on the next clock edge, and the bit stays set until it is cleared.
- R3: A read (`rd_en` high) of a status register clears that register at the clock edge. No other register is affected.
- R4: An event that arrives in the same cycle as a clearing read of its register is set after the read.
- R5: Mask registers store what is written to them and read back the same value.
- R6: `irq` is high exactly when some status bit is 1 and its mask bit is 0. A mask bit of 1 blocks its status bit.
- R7: After `rst_n` is asserted, every status and mask bit is 0, `irq` is 0 and `mgmt_rst` is 0.
- R8: Packet status bit 0 is frame sent and bit 1 is management frame received. Both clear on read. Packet control bits 0 and 1 are their masks.
- R9: Writing a 1 to packet control bit 2 raises `mgmt_rst` for exactly one cycle, starting at the edge after the write. Control bit 2 reads 1 only during that cycle. When the cycle ends, all status and mask bits are 0, and events and accesses made during that cycle have no effect.
- R10: Writes to status registers, and to the packet status register, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_sel | input | 3 | Register select |
| rd_en | input | 1 | Read strobe; clears a selected status register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Contents of selected register |
| link_ev | input | 8 | Link change pulse per port |
| part_ev | input | 8 | Partition change pulse per port |
| rate_ev | input | 8 | Data-rate mismatch pulse per port |
| jab_ev | input | 8 | Jabber pulse per port |
| iso_ev | input | 8 | Isolation pulse per port |
| sachg_ev | input | 8 | Source-address change pulse per port |
| tx_done_ev | input | 1 | Frame sent pulse |
| mgmt_rx_ev | input | 1 | Management frame received pulse |
| irq | output | 1 | Combined interrupt |
| mgmt_rst | output | 1 | One-cycle soft reset for the management block |

## Verification
The bench builds the bank with its default of eight ports, which makes each register exactly 16 bits wide. Every port bit of both bytes in all three groups can therefore be reached through the normal register interface. Sparse random event pulses, mixed with random reads and mask writes, exercise the cases where a sticky bit, a clearing read and a new event all meet in the same cycle. Directed sequences cover the packet pair, the ignored status writes and the soft-reset sequence with events arriving during `SR_FIRE`.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
    localparam int SEL_W = 3;
    localparam logic [SEL_W-1:0] SEL_PKT_ST  = 3'd6;
    localparam logic [SEL_W-1:0] SEL_PKT_CTL = 3'd7;
    localparam int CTL_SRST_BIT = 2;

    typedef enum logic {
        SR_IDLE,
        SR_FIRE
    } sr_state_t;
endpackage

// File: rtl/irq_stat_pair.sv
module irq_stat_pair #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic [W-1:0]   ev_lo,
    input  logic [W-1:0]   ev_hi,
    input  logic           rd_clr,
    input  logic           mk_we,
    input  logic [2*W-1:0] mk_wdata,
    output logic [2*W-1:0] status,
    output logic [2*W-1:0] mask,
    output logic           pend
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
            mask   <= '0;
        end else if (clr) begin
            status <= '0;
            mask   <= '0;
        end else begin
            status <= (rd_clr ? '0 : status) | {ev_hi, ev_lo};
            if (mk_we) begin
                mask <= mk_wdata;
            end
        end
    end

    assign pend = |(status & ~mask);
endmodule

// File: rtl/irq_srst_fsm.sv
module irq_srst_fsm
    import irq_bank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic fire
);
    sr_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SR_IDLE: if (trig) state_d = SR_FIRE;
            SR_FIRE: state_d = SR_IDLE;
        endcase
    end

    always_comb begin
        fire = 1'b0;
        unique case (state_q)
            SR_IDLE: fire = 1'b0;
            SR_FIRE: fire = 1'b1;
        endcase
    end
endmodule

// File: rtl/irq_bank.sv
module irq_bank
    import irq_bank_pkg::*;
#(
    parameter int NPORTS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SEL_W-1:0]      reg_sel,
    input  logic                  rd_en,
    input  logic                  wr_en,
    input  logic [2*NPORTS-1:0]   wr_data,
    output logic [2*NPORTS-1:0]   rd_data,
    input  logic [NPORTS-1:0]     link_ev,
    input  logic [NPORTS-1:0]     part_ev,
    input  logic [NPORTS-1:0]     rate_ev,
    input  logic [NPORTS-1:0]     jab_ev,
    input  logic [NPORTS-1:0]     iso_ev,
    input  logic [NPORTS-1:0]     sachg_ev,
    input  logic                  tx_done_ev,
    input  logic                  mgmt_rx_ev,
    output logic                  irq,
    output logic                  mgmt_rst
);
    localparam int DW   = 2 * NPORTS;
    localparam int NGRP = 3;

    logic [NGRP-1:0][NPORTS-1:0] ev_lo, ev_hi;
    logic [NGRP-1:0][DW-1:0]     st_arr, mk_arr;
    logic [NGRP-1:0]             pend_vec;
    logic [NGRP*DW-1:0]          st_flat, mk_flat;
    logic [1:0]                  pkt_st, pkt_mk;
    logic                        pkt_pend;
    logic                        fire;
    logic                        srst_trig;

    assign ev_lo = {iso_ev, rate_ev, link_ev};
    assign ev_hi = {sachg_ev, jab_ev, part_ev};

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        irq_stat_pair #(.W(NPORTS)) u_pair (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (fire),
            .ev_lo    (ev_lo[g]),
            .ev_hi    (ev_hi[g]),
            .rd_clr   (rd_en && (reg_sel == SEL_W'(2*g))),
            .mk_we    (wr_en && (reg_sel == SEL_W'(2*g+1))),
            .mk_wdata (wr_data),
            .status   (st_arr[g]),
            .mask     (mk_arr[g]),
            .pend     (pend_vec[g])
        );
    end

    irq_stat_pair #(.W(1)) u_pkt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (fire),
        .ev_lo    (tx_done_ev),
        .ev_hi    (mgmt_rx_ev),
        .rd_clr   (rd_en && (reg_sel == SEL_PKT_ST)),
        .mk_we    (wr_en && (reg_sel == SEL_PKT_CTL)),
        .mk_wdata (wr_data[1:0]),
        .status   (pkt_st),
        .mask     (pkt_mk),
        .pend     (pkt_pend)
    );

    assign srst_trig = wr_en && (reg_sel == SEL_PKT_CTL) && wr_data[CTL_SRST_BIT];

    irq_srst_fsm u_srst (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (srst_trig),
        .fire  (fire)
    );

    always_comb begin
        rd_data = '0;
        for (int g = 0; g < NGRP; g++) begin
            if (reg_sel == SEL_W'(2*g))   rd_data = st_arr[g];
            if (reg_sel == SEL_W'(2*g+1)) rd_data = mk_arr[g];
        end
        if (reg_sel == SEL_PKT_ST)  rd_data = DW'(pkt_st);
        if (reg_sel == SEL_PKT_CTL) rd_data = DW'({fire, pkt_mk});
    end

    assign st_flat  = st_arr;
    assign mk_flat  = mk_arr;
    assign irq      = (|pend_vec) | pkt_pend;
    assign mgmt_rst = fire;
endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk #(
    parameter int NPORTS = 8,
    parameter int NGRP   = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [2:0]               reg_sel,
    input logic                     rd_en,
    input logic                     wr_en,
    input logic [NPORTS-1:0]        link_ev,
    input logic [NPORTS-1:0]        part_ev,
    input logic                     irq,
    input logic                     mgmt_rst,
    input logic [NGRP*2*NPORTS-1:0] st_flat,
    input logic [NGRP*2*NPORTS-1:0] mk_flat,
    input logic [1:0]               pkt_st,
    input logic [1:0]               pkt_mk
);
    localparam int DW = 2 * NPORTS;
    logic [DW-1:0] lp_ev;
    logic [DW-1:0] lp_st;
    logic          any_open;

    assign lp_ev    = {part_ev, link_ev};
    assign lp_st    = st_flat[DW-1:0];
    assign any_open = ((st_flat & ~mk_flat) != '0) || ((pkt_st & ~pkt_mk) != '0);

    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (!mgmt_rst && lp_ev != '0) |=> ((lp_st & $past(lp_ev)) == $past(lp_ev)));

    a_r4_read_keeps_new: assert property (@(posedge clk) disable iff (!rst_n)
        (!mgmt_rst && rd_en && reg_sel == 3'd0) |=> (lp_st == $past(lp_ev)));

    a_r10_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!mgmt_rst && wr_en && !rd_en && reg_sel == 3'd0 && lp_ev == '0) |=> $stable(lp_st));

    a_r6_irq_active: assert property (@(posedge clk) disable iff (!rst_n)
        any_open |-> irq);

    a_r6_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !any_open |-> !irq);

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_rst |=> !mgmt_rst);

    a_r9_clears_all: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_rst |=> (st_flat == '0 && mk_flat == '0 && pkt_st == '0 && pkt_mk == '0));
endmodule

bind irq_bank irq_bank_chk #(.NPORTS(NPORTS), .NGRP(NGRP)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_sel  (reg_sel),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .link_ev  (link_ev),
    .part_ev  (part_ev),
    .irq      (irq),
    .mgmt_rst (mgmt_rst),
    .st_flat  (st_flat),
    .mk_flat  (mk_flat),
    .pkt_st   (pkt_st),
    .pkt_mk   (pkt_mk)
);

// File: tb/irq_bank_tb_top.sv
module irq_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [7:0]  link_ev = '0, part_ev = '0, rate_ev = '0, jab_ev = '0, iso_ev = '0, sachg_ev = '0;
    logic        tx_done_ev = 1'b0, mgmt_rx_ev = 1'b0;
    logic        irq, mgmt_rst;

    int checks = 0;
    int fails  = 0;

    logic [15:0] m_st [3];
    logic [15:0] m_mk [3];
    logic [1:0]  m_pst, m_pmk;
    logic        m_fire;

    always #2 clk = ~clk;

    irq_bank dut_i (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .link_ev(link_ev), .part_ev(part_ev),
        .rate_ev(rate_ev), .jab_ev(jab_ev), .iso_ev(iso_ev), .sachg_ev(sachg_ev),
        .tx_done_ev(tx_done_ev), .mgmt_rx_ev(mgmt_rx_ev), .irq(irq), .mgmt_rst(mgmt_rst)
    );

    function automatic logic [15:0] exp_rd(input logic [2:0] sel);
        case (sel)
            3'd0, 3'd2, 3'd4: return m_st[sel/2];
            3'd1, 3'd3, 3'd5: return m_mk[sel/2];
            3'd6:             return {14'b0, m_pst};
            default:          return {13'b0, m_fire, m_pmk};
        endcase
    endfunction

    function automatic logic exp_irq();
        logic r = |(m_pst & ~m_pmk);
        for (int g = 0; g < 3; g++) r |= |(m_st[g] & ~m_mk[g]);
        return r;
    endfunction

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ev packs groups: [g*16 +: 8] low byte event, [g*16+8 +: 8] high byte event
    task automatic cycle(input logic [2:0] sel, input logic rd, input logic wr,
                         input logic [15:0] wd, input logic [47:0] ev,
                         input logic [1:0] pev, input string tag);
        @(negedge clk);
        reg_sel = sel; rd_en = rd; wr_en = wr; wr_data = wd;
        link_ev = ev[7:0];   part_ev  = ev[15:8];
        rate_ev = ev[23:16]; jab_ev   = ev[31:24];
        iso_ev  = ev[39:32]; sachg_ev = ev[47:40];
        tx_done_ev = pev[0]; mgmt_rx_ev = pev[1];
        #1;
        if (rd) check(rd_data, exp_rd(sel), {tag, " R1 read"});
        check({15'b0, irq}, {15'b0, exp_irq()}, "R6 irq");
        check({15'b0, mgmt_rst}, {15'b0, m_fire}, "R9 mgmt_rst");
        @(posedge clk);
        if (m_fire) begin
            for (int g = 0; g < 3; g++) begin m_st[g] = '0; m_mk[g] = '0; end
            m_pst = '0; m_pmk = '0; m_fire = 1'b0;
        end else begin
            for (int g = 0; g < 3; g++) begin
                if (rd && sel == 3'(2*g)) m_st[g] = '0;
                m_st[g] |= ev[g*16 +: 16];
                if (wr && sel == 3'(2*g+1)) m_mk[g] = wd;
            end
            if (rd && sel == 3'd6) m_pst = '0;
            m_pst |= pev;
            if (wr && sel == 3'd7) begin
                m_pmk = wd[1:0];
                if (wd[2]) m_fire = 1'b1;
            end
        end
    endtask

    task automatic idle(); cycle(3'd0, 1'b0, 1'b0, 16'h0, 48'h0, 2'b0, "idle"); endtask

    task automatic read_all(input string tag);
        for (int s = 0; s < 8; s++) cycle(3'(s), 1'b1, 1'b0, 16'h0, 48'h0, 2'b0, tag);
    endtask

    initial begin
        #(4 * 100000);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int g = 0; g < 3; g++) begin m_st[g] = '0; m_mk[g] = '0; end
        m_pst = '0; m_pmk = '0; m_fire = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R7: reset state of every register
        read_all("R7 reset");

        // R2 + R1: link port 3 low byte, partition port 5 high byte
        cycle(3'd0, 1'b0, 1'b0, 16'h0, 48'h0000_0000_2008, 2'b0, "R2 set");
        idle(); idle();
        cycle(3'd0, 1'b1, 1'b0, 16'h0, 48'h0, 2'b0, "R2 sticky");
        // R3: now cleared, other groups untouched
        cycle(3'd2, 1'b0, 1'b0, 16'h0, 48'h0000_8000_0000, 2'b0, "R3 prep");
        cycle(3'd0, 1'b1, 1'b0, 16'h0, 48'h0, 2'b0, "R3 cleared");
        cycle(3'd2, 1'b1, 1'b0, 16'h0, 48'h0, 2'b0, "R3 other kept");
        // R4: event with clearing read in same cycle
        cycle(3'd4, 1'b0, 1'b0, 16'h0, 48'h0040_0000_0000, 2'b0, "R4 prep");
        cycle(3'd4, 1'b1, 1'b0, 16'h0, 48'h0002_0000_0000, 2'b0, "R4 read");
        cycle(3'd4, 1'b1, 1'b0, 16'h0, 48'h0, 2'b0, "R4 kept");
        // R5/R6: masks block irq
        cycle(3'd0, 1'b0, 1'b0, 16'h0, 48'h0000_0000_0001, 2'b0, "R6 set");
        cycle(3'd1, 1'b0, 1'b1, 16'h0001, 48'h0, 2'b0, "R5 mask");
        cycle(3'd1, 1'b1, 1'b0, 16'h0, 48'h0, 2'b0, "R5 readback");
        cycle(3'd1, 1'b0, 1'b1, 16'h0000, 48'h0, 2'b0, "R6 unmask");
        idle();
        // R10: status write ignored
        cycle(3'd0, 1'b0, 1'b1, 16'hFFFF, 48'h0, 2'b0, "R10 write");
        cycle(3'd0, 1'b1, 1'b0, 16'h0, 48'h0, 2'b0, "R10 unchanged");
        cycle(3'd6, 1'b0, 1'b1, 16'h0003, 48'h0, 2'b0, "R10 pkt write");
        cycle(3'd6, 1'b1, 1'b0, 16'h0, 48'h0, 2'b0, "R10 pkt unchanged");
        // R8: packet events and masks
        cycle(3'd0, 1'b0, 1'b0, 16'h0, 48'h0, 2'b01, "R8 tx");
        cycle(3'd7, 1'b0, 1'b1, 16'h0001, 48'h0, 2'b10, "R8 rx+mask");
        cycle(3'd6, 1'b1, 1'b0, 16'h0, 48'h0, 2'b0, "R8 read");
        cycle(3'd7, 1'b1, 1'b0, 16'h0, 48'h0, 2'b0, "R8 ctl");
        cycle(3'd6, 1'b1, 1'b0, 16'h0, 48'h0, 2'b0, "R8 cleared");
        // R9: soft reset with pending bits and masks
        cycle(3'd3, 1'b0, 1'b1, 16'hA5A5, 48'h0001_0100_1000, 2'b11, "R9 prep");
        cycle(3'd7, 1'b0, 1'b1, 16'h0004, 48'h0, 2'b0, "R9 trigger");
        cycle(3'd7, 1'b1, 1'b1, 16'h0003, 48'hFFFF_FFFF_FFFF, 2'b11, "R9 fire");
        read_all("R9 after");

        // random traffic, soft-reset bit kept low
        for (int i = 0; i < 600; i++) begin
            logic [47:0] ev;
            logic [2:0]  s  = 3'($urandom);
            logic        rd = 1'($urandom);
            logic        wr = ($urandom % 4) == 0;
            logic [15:0] wd = 16'($urandom);
            if (s == 3'd7) wd[2] = 1'b0;
            ev = {16'($urandom & $urandom & $urandom),
                  16'($urandom & $urandom & $urandom),
                  16'($urandom & $urandom & $urandom)};
            cycle(s, rd, wr, wd, ev, 2'($urandom & $urandom), "R2 R3 R4 R5 random");
        end
        read_all("R1 final");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule